// File: doc/BRIEF.md
# Framed Serial Audio Transmitter

This block serialises audio words onto one data line, framed by a frame-sync input. The serial bit clock and the frame sync both come from outside the block, and the block samples them in its own system clock domain. A bus master or a DMA engine writes each word into a single holding register. The block asks for the next word through a request output. At the start of each word slot it moves the held word into a shift register and sends it MSB first, on the bit-clock edge that software selects.

Software sets five things: the sample width (a 3-bit code), the number of words per frame, the data delay after frame sync (0, 1 or 2 bit clocks), the launch edge and the frame-sync polarity. A frame sync that arrives before the current frame has finished can either restart the frame and raise a sticky error flag, or be ignored. An enable input acts as the transmitter reset. While it is low the block stays idle. After it rises, the block only becomes operational once a set number of bit-clock edges has been seen. If no word is waiting when a slot starts, the previous word is sent again and a sticky underrun flag is set.

Top module: `framed_audio_tx`

## Requirements
- R1: `word_len_code` selects the number of bits sent per word: 0 gives 8, 1 gives 12, 2 gives 16, 3 gives 20, 4 gives 24, and 5 to 7 give 32. The low bits of the held word are sent MSB first, and any holding-register bits above the selected width have no effect on `sdata`.
- R2: One frame carries `frame_words_m1`+1 words back to back with no gap between them. `sdata` is 0 on every launch edge outside the data window.
- R3: `data_delay` sets the number of launch edges between the edge that detects frame sync and the edge that drives the first data bit: 0, 1 or 2. The value 3 behaves as 2.
- R4: With `launch_on_fall`=1 data changes after falling `bclk` edges and is stable at rising edges. With 0 it changes after rising edges and is stable at falling edges.
- R5: A frame starts at a launch edge where the sampled `fsync` is at its active level and was not active at the previous launch edge. The active level is high when `fsync_active_low`=0 and low when it is 1.
- R6: With `ignore_early_fs`=0, a frame start that arrives while a frame (including its delay) is still in progress restarts the frame from the delay phase with the next word. It also sets `sync_err`, which stays set while `tx_en` is high.
- R7: With `ignore_early_fs`=1, a frame start that arrives during a frame has no effect: the frame completes unchanged and `sync_err` stays 0.
- R8: While `tx_en` is 0, `sdata`, `req`, `sync_err` and `underrun` are 0, the holding register is emptied, and writes are dropped.
- R9: After `tx_en` rises, the transmitter is not operational until ARM_EDGES (default 2) launch edges of `bclk` have been seen. Until then `req` stays 0 and frame syncs are ignored.
- R10: `req` is 1 exactly when the transmitter is operational and the holding register is empty. A write fills the register, and `req` is 0 in the following cycle.
- R11: If a word slot starts with the holding register empty, the previous word is sent again and `underrun` is set. `underrun` stays set until `tx_en` goes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_en | input | 1 | Transmitter enable; low holds it in reset |
| bclk | input | 1 | External serial bit clock |
| fsync | input | 1 | External frame sync |
| launch_on_fall | input | 1 | 1: launch data on falling bclk edges |
| fsync_active_low | input | 1 | 1: frame sync active low |
| ignore_early_fs | input | 1 | 1: ignore frame sync during a frame |
| word_len_code | input | 3 | Sample width code |
| frame_words_m1 | input | FRAME_LEN_W | Words per frame minus one |
| data_delay | input | 2 | Bit clocks from frame sync to first bit |
| wr_en | input | 1 | Holding register write strobe |
| wr_data | input | WORD_W | Word to send |
| sdata | output | 1 | Serial data |
| req | output | 1 | Request for the next word |
| sync_err | output | 1 | Sticky early frame-sync flag |
| underrun | output | 1 | Sticky underrun flag |

## Verification
The assertions assume that `bclk` stays at each level for at least SYNC_STAGES+1 system clocks. They also assume that `fsync` changes only on the non-launch edge, so that it is stable whenever a launch edge is detected. The stimulus keeps each bit-clock half period at eight system clocks and moves `fsync` half a bit period before each launch edge. Configuration inputs change only while `tx_en` is low. Writes are issued only while `req` is high, so a write never meets a word fetch in the same cycle.

// File: rtl/audio_tx_pkg.sv
package audio_tx_pkg;

  typedef enum logic [1:0] {
    TX_IDLE  = 2'd0,
    TX_DELAY = 2'd1,
    TX_SHIFT = 2'd2
  } tx_state_e;

  // Bits per word for each width code.
  function automatic logic [5:0] width_of(input logic [2:0] code);
    case (code)
      3'd0:    width_of = 6'd8;
      3'd1:    width_of = 6'd12;
      3'd2:    width_of = 6'd16;
      3'd3:    width_of = 6'd20;
      3'd4:    width_of = 6'd24;
      default: width_of = 6'd32;
    endcase
  endfunction

endpackage

// File: rtl/atx_edge_sync.sv
module atx_edge_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic bclk_i,
  input  logic fs_i,
  input  logic launch_fall_i,
  input  logic fs_low_i,
  output logic launch_o,
  output logic fs_act_o
);
  localparam int BPW = SYNC_STAGES + 1;

  logic [BPW-1:0]         bclk_pipe;
  logic [SYNC_STAGES-1:0] fs_pipe;

  always_ff @(posedge clk) begin
    if (rst) begin
      bclk_pipe <= '0;
      fs_pipe   <= '0;
    end else begin
      bclk_pipe <= {bclk_pipe[BPW-2:0], bclk_i};
      fs_pipe   <= {fs_pipe[SYNC_STAGES-2:0], fs_i};
    end
  end

  logic cur_lvl, prv_lvl;
  assign cur_lvl  = bclk_pipe[SYNC_STAGES-1];
  assign prv_lvl  = bclk_pipe[SYNC_STAGES];
  // A launch pulse lasts one system clock after the selected bclk edge.
  assign launch_o = launch_fall_i ? (prv_lvl & ~cur_lvl) : (cur_lvl & ~prv_lvl);
  assign fs_act_o = fs_pipe[SYNC_STAGES-1] ^ fs_low_i;

endmodule

// File: rtl/atx_hold.sv
module atx_hold #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en_i,
  input  logic         armed_i,
  input  logic         wr_i,
  input  logic [W-1:0] wr_data_i,
  input  logic         take_i,
  output logic [W-1:0] word_o,
  output logic         req_o,
  output logic         underrun_o
);
  logic [W-1:0] hold_q, last_q;
  logic         full_q, urun_q;

  always_ff @(posedge clk) begin
    if (rst || !en_i) begin
      hold_q <= '0;
      last_q <= '0;
      full_q <= 1'b0;
      urun_q <= 1'b0;
    end else begin
      if (take_i) begin
        if (full_q) last_q <= hold_q;
        else        urun_q <= 1'b1;
        full_q <= 1'b0;
      end
      if (wr_i) begin
        hold_q <= wr_data_i;
        full_q <= 1'b1;
      end
    end
  end

  assign word_o     = full_q ? hold_q : last_q;
  assign req_o      = en_i & armed_i & ~full_q;
  assign underrun_o = urun_q;

  // R10
  wr_fill_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_i && en_i) |=> !req_o);
  // R11
  underrun_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (underrun_o && en_i) |=> underrun_o);
  // R8
  underrun_clear_chk: assert property (@(posedge clk) disable iff (rst)
    !en_i |=> (!underrun_o && !req_o));

endmodule

// File: rtl/atx_shift.sv
module atx_shift
  import audio_tx_pkg::*;
#(
  parameter int W           = 32,
  parameter int FRL_W       = 3,
  parameter int ARM_EDGES   = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en_i,
  input  logic             launch_i,
  input  logic             fs_act_i,
  input  logic [2:0]       wlen_code_i,
  input  logic [FRL_W-1:0] frlen_i,
  input  logic [1:0]       delay_i,
  input  logic             ignore_fs_i,
  input  logic [W-1:0]     word_i,
  output logic             take_o,
  output logic             armed_o,
  output logic             sdata_o,
  output logic             sync_err_o
);
  localparam int BCW    = $clog2(W);
  localparam int ARM_CW = $clog2(ARM_EDGES + 1);

  tx_state_e        state_q;
  logic [W-1:0]     sh_q;
  logic [BCW-1:0]   bits_left_q;
  logic [FRL_W-1:0] words_left_q;
  logic [1:0]       dly_left_q;
  logic             fs_prev_q;
  logic [ARM_CW-1:0] arm_cnt_q;
  logic             sdata_q, serr_q;

  logic [5:0]   wbits;
  logic [5:0]   shamt;
  logic [W-1:0] aligned;
  logic [1:0]   dly_eff;
  logic         fs_start, restart, start_word;

  always_comb begin
    armed_o  = (arm_cnt_q == ARM_CW'(ARM_EDGES));
    wbits    = width_of(wlen_code_i);
    shamt    = 6'(W) - wbits;
    aligned  = word_i << shamt;
    dly_eff  = (delay_i == 2'd3) ? 2'd2 : delay_i;
    fs_start = armed_o & launch_i & fs_act_i & ~fs_prev_q;
    restart  = fs_start & ((state_q == TX_IDLE) | ~ignore_fs_i);
    start_word = 1'b0;
    if (armed_o && launch_i) begin
      if (restart)
        start_word = (dly_eff == 2'd0);
      else if (state_q == TX_DELAY)
        start_word = (dly_left_q == 2'd0);
      else if (state_q == TX_SHIFT)
        start_word = (bits_left_q == '0) && (words_left_q != '0);
    end
  end

  assign take_o = start_word;

  always_ff @(posedge clk) begin
    if (rst || !en_i) begin
      state_q      <= TX_IDLE;
      sh_q         <= '0;
      bits_left_q  <= '0;
      words_left_q <= '0;
      dly_left_q   <= '0;
      fs_prev_q    <= 1'b0;
      arm_cnt_q    <= '0;
      sdata_q      <= 1'b0;
      serr_q       <= 1'b0;
    end else if (launch_i) begin
      fs_prev_q <= fs_act_i;
      if (!armed_o) begin
        arm_cnt_q <= arm_cnt_q + ARM_CW'(1);
      end else begin
        if (restart) begin
          if (state_q != TX_IDLE) serr_q <= 1'b1;
          words_left_q <= frlen_i;
          state_q      <= TX_DELAY;
          dly_left_q   <= dly_eff - 2'd1;
          sdata_q      <= 1'b0;
        end else begin
          case (state_q)
            TX_DELAY: if (dly_left_q != 2'd0) dly_left_q <= dly_left_q - 2'd1;
            TX_SHIFT: begin
              if (bits_left_q != '0) begin
                sdata_q     <= sh_q[W-1];
                sh_q        <= sh_q << 1;
                bits_left_q <= bits_left_q - BCW'(1);
              end else if (words_left_q != '0) begin
                words_left_q <= words_left_q - FRL_W'(1);
              end else begin
                state_q <= TX_IDLE;
                sdata_q <= 1'b0;
              end
            end
            default: sdata_q <= 1'b0;
          endcase
        end
        // Word load overrides the per-state updates above.
        if (start_word) begin
          state_q     <= TX_SHIFT;
          sdata_q     <= aligned[W-1];
          sh_q        <= aligned << 1;
          bits_left_q <= BCW'(wbits - 6'd1);
        end
      end
    end
  end

  assign sdata_o    = sdata_q;
  assign sync_err_o = serr_q;

  // R8
  idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !en_i |=> (!sdata_o && !sync_err_o));
  // R6
  sync_err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (sync_err_o && en_i) |=> sync_err_o);
  // R9
  arm_on_edge_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(armed_o) |-> $past(launch_i));
  // R2
  sdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (en_i && !launch_i) |=> $stable(sdata_o));

endmodule

// File: rtl/framed_audio_tx.sv
module framed_audio_tx #(
  parameter int WORD_W      = 32,
  parameter int FRAME_LEN_W = 3,
  parameter int SYNC_STAGES = 2,
  parameter int ARM_EDGES   = 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   tx_en,
  input  logic                   bclk,
  input  logic                   fsync,
  input  logic                   launch_on_fall,
  input  logic                   fsync_active_low,
  input  logic                   ignore_early_fs,
  input  logic [2:0]             word_len_code,
  input  logic [FRAME_LEN_W-1:0] frame_words_m1,
  input  logic [1:0]             data_delay,
  input  logic                   wr_en,
  input  logic [WORD_W-1:0]      wr_data,
  output logic                   sdata,
  output logic                   req,
  output logic                   sync_err,
  output logic                   underrun
);
  logic              launch, fs_act, take, armed;
  logic [WORD_W-1:0] cur_word;

  atx_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .bclk_i(bclk), .fs_i(fsync),
    .launch_fall_i(launch_on_fall), .fs_low_i(fsync_active_low),
    .launch_o(launch), .fs_act_o(fs_act)
  );

  atx_hold #(.W(WORD_W)) u_hold (
    .clk(clk), .rst(rst), .en_i(tx_en), .armed_i(armed),
    .wr_i(wr_en), .wr_data_i(wr_data), .take_i(take),
    .word_o(cur_word), .req_o(req), .underrun_o(underrun)
  );

  atx_shift #(.W(WORD_W), .FRL_W(FRAME_LEN_W), .ARM_EDGES(ARM_EDGES)) u_shift (
    .clk(clk), .rst(rst), .en_i(tx_en), .launch_i(launch), .fs_act_i(fs_act),
    .wlen_code_i(word_len_code), .frlen_i(frame_words_m1), .delay_i(data_delay),
    .ignore_fs_i(ignore_early_fs), .word_i(cur_word),
    .take_o(take), .armed_o(armed), .sdata_o(sdata), .sync_err_o(sync_err)
  );

endmodule

// File: tb/framed_audio_tx_bench.sv
module framed_audio_tx_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tx_en = 1'b0, bclk = 1'b0, fsync = 1'b0;
  logic        launch_on_fall = 1'b0, fsync_active_low = 1'b0, ignore_early_fs = 1'b0;
  logic [2:0]  word_len_code = 3'd2;
  logic [2:0]  frame_words_m1 = 3'd1;
  logic [1:0]  data_delay = 2'd0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic        sdata, req, sync_err, underrun;

  always #2.5 clk = ~clk;

  framed_audio_tx u_framed_audio_tx (
    .clk(clk), .rst(rst), .tx_en(tx_en), .bclk(bclk), .fsync(fsync),
    .launch_on_fall(launch_on_fall), .fsync_active_low(fsync_active_low),
    .ignore_early_fs(ignore_early_fs), .word_len_code(word_len_code),
    .frame_words_m1(frame_words_m1), .data_delay(data_delay),
    .wr_en(wr_en), .wr_data(wr_data), .sdata(sdata), .req(req),
    .sync_err(sync_err), .underrun(underrun)
  );

  int checks = 0, fails = 0;
  logic [31:0] feed [8];
  int feed_cnt = 0, feed_idx = 0;
  logic feed_force = 1'b0;
  logic cap [128];
  logic expv [128];
  int nexp = 0;

  typedef struct packed {
    logic [2:0] wl; logic [2:0] fr; logic [1:0] dl;
    logic cp; logic fp; logic [7:0] nbits;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{3'd2, 3'd1, 2'd1, 1'b1, 1'b0, 8'd32},
    '{3'd0, 3'd0, 2'd0, 1'b0, 1'b0, 8'd8},
    '{3'd1, 3'd2, 2'd2, 1'b0, 1'b1, 8'd36},
    '{3'd3, 3'd1, 2'd0, 1'b1, 1'b1, 8'd40},
    '{3'd4, 3'd1, 2'd1, 1'b0, 1'b0, 8'd48},
    '{3'd5, 3'd1, 2'd2, 1'b1, 1'b0, 8'd64},
    '{3'd2, 3'd3, 2'd1, 1'b0, 1'b1, 8'd64},
    '{3'd0, 3'd1, 2'd3, 1'b0, 1'b1, 8'd16}
  };

  function automatic int wbits(input logic [2:0] c);
    case (c)
      3'd0: return 8;  3'd1: return 12; 3'd2: return 16;
      3'd3: return 20; 3'd4: return 24; default: return 32;
    endcase
  endfunction

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not complete (actual hung, expected done)");
    report();
  end

  // Word feeder: writes whenever the block requests a word.
  initial forever begin
    @(negedge clk);
    if ((req || feed_force) && feed_idx < feed_cnt) begin
      wr_en   = 1'b1;
      wr_data = feed[feed_idx];
      feed_idx++;
    end else begin
      wr_en = 1'b0;
    end
  end

  task automatic chk(input string r, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b", r, act, exp);
    end
  endtask

  // One bit period: set fsync, launch edge, then capture edge.
  task automatic tick(input logic fs_on, output logic sd);
    fsync = fs_on ^ fsync_active_low;
    repeat (8) @(negedge clk);
    bclk = ~launch_on_fall;
    repeat (8) @(negedge clk);
    sd = sdata;
    bclk = launch_on_fall;
  endtask

  task automatic run_cap(input int n, input int fs2);
    for (int i = 0; i < n; i++) begin
      logic b;
      tick((i == 0) || (fs2 > 0 && i == fs2), b);
      cap[i] = b;
    end
  endtask

  task automatic exp_clear();
    for (int i = 0; i < 128; i++) expv[i] = 1'b0;
    nexp = 0;
  endtask

  task automatic exp_bits(input logic [31:0] wd, input int hi, input int lo);
    for (int b = hi; b >= lo; b--) begin
      expv[nexp] = wd[b];
      nexp++;
    end
  endtask

  task automatic chk_stream(input string r, input int n);
    int bad = 0, first = -1;
    for (int i = 0; i < n; i++)
      if (cap[i] !== expv[i]) begin
        bad++;
        if (first < 0) first = i;
      end
    checks++;
    if (bad != 0) begin
      fails++;
      $display("FAIL %s: bit %0d actual %b expected %b (%0d bad bits)",
               r, first, cap[first], expv[first], bad);
    end
  endtask

  task automatic setup(input logic [2:0] wl, input logic [2:0] fr, input logic [1:0] dl,
                       input logic cp, input logic fp, input logic ig);
    tx_en = 1'b0;
    feed_cnt = 0;
    repeat (2) @(negedge clk);
    word_len_code = wl; frame_words_m1 = fr; data_delay = dl;
    launch_on_fall = cp; fsync_active_low = fp; ignore_early_fs = ig;
    bclk = cp; fsync = fp;
    feed_idx = 0;
    repeat (6) @(negedge clk);
  endtask

  task automatic arm();
    logic b;
    tx_en = 1'b1;
    repeat (2) @(negedge clk);
    for (int i = 0; i < 3; i++) tick(1'b0, b);
  endtask

  initial begin
    logic b;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    // R8 reset state
    chk("R8 reset sdata", sdata, 1'b0);
    chk("R8 reset req", req, 1'b0);
    chk("R8 reset sync_err", sync_err, 1'b0);
    chk("R8 reset underrun", underrun, 1'b0);

    // Table of configurations (R1 R2 R3 R4 R5)
    for (int v = 0; v < 8; v++) begin
      int w, d, nw;
      w  = wbits(VECS[v].wl);
      nw = int'(VECS[v].fr) + 1;
      d  = (VECS[v].dl == 2'd3) ? 2 : int'(VECS[v].dl);
      setup(VECS[v].wl, VECS[v].fr, VECS[v].dl, VECS[v].cp, VECS[v].fp, 1'b0);
      for (int k = 0; k < nw; k++) feed[k] = 32'h9E37_79B9 * 32'(v * 8 + k + 1);
      feed_cnt = nw;
      arm();
      exp_clear();
      nexp = d;
      for (int k = 0; k < nw; k++) exp_bits(feed[k], w - 1, 0);
      if (nexp - d != int'(VECS[v].nbits)) begin
        checks++; fails++;
        $display("FAIL R2 table row %0d: actual %0d bits expected %0d", v, nexp - d, VECS[v].nbits);
      end
      run_cap(nexp + 3, 0);
      chk_stream($sformatf("R1 R2 R3 R4 R5 vector %0d", v), nexp + 3);
      chk("R11 no underrun", underrun, 1'b0);
      chk("R6 no sync_err", sync_err, 1'b0);
    end

    // R6: early frame sync restarts the frame and flags it
    setup(3'd2, 3'd1, 2'd1, 1'b0, 1'b0, 1'b0);
    feed[0] = 32'hFFFF_A3C5; feed[1] = 32'h0000_5E17; feed[2] = 32'h1234_C0DE;
    feed_cnt = 3;
    arm();
    exp_clear();
    nexp = 1; exp_bits(feed[0], 15, 7); nexp++;
    exp_bits(feed[1], 15, 0); exp_bits(feed[2], 15, 0);
    run_cap(nexp + 3, 10);
    chk_stream("R6 restart stream", nexp + 3);
    chk("R6 sync_err set", sync_err, 1'b1);
    tx_en = 1'b0;
    repeat (3) @(negedge clk);
    chk("R8 sync_err cleared", sync_err, 1'b0);

    // R7: early frame sync ignored
    setup(3'd2, 3'd1, 2'd1, 1'b0, 1'b0, 1'b1);
    feed[0] = 32'h0000_B00F; feed[1] = 32'hABCD_6A59;
    feed_cnt = 2;
    arm();
    exp_clear();
    nexp = 1; exp_bits(feed[0], 15, 0); exp_bits(feed[1], 15, 0);
    run_cap(nexp + 3, 10);
    chk_stream("R7 ignored stream", nexp + 3);
    chk("R7 sync_err clear", sync_err, 1'b0);

    // R11: underrun repeats the last word
    setup(3'd2, 3'd1, 2'd0, 1'b1, 1'b0, 1'b0);
    feed[0] = 32'h0000_C3A1;
    feed_cnt = 1;
    arm();
    exp_clear();
    exp_bits(feed[0], 15, 0); exp_bits(feed[0], 15, 0);
    run_cap(nexp + 3, 0);
    chk_stream("R11 repeated word", nexp + 3);
    chk("R11 underrun set", underrun, 1'b1);
    tx_en = 1'b0;
    repeat (3) @(negedge clk);
    chk("R8 underrun cleared", underrun, 1'b0);

    // R9: reset completes only after bit-clock edges
    setup(3'd2, 3'd1, 2'd0, 1'b0, 1'b0, 1'b0);
    tx_en = 1'b1;
    repeat (20) @(negedge clk);
    chk("R9 req low with idle bclk", req, 1'b0);
    tick(1'b0, b);
    chk("R9 req low after one edge", req, 1'b0);
    tick(1'b0, b);
    chk("R10 req high once operational", req, 1'b1);

    // R8: writes while disabled are dropped
    setup(3'd2, 3'd1, 2'd0, 1'b0, 1'b0, 1'b0);
    feed[0] = 32'h0000_7777;
    feed_cnt = 1;
    feed_force = 1'b1;
    repeat (3) @(negedge clk);
    feed_force = 1'b0;
    arm();
    chk("R8 write while disabled dropped", req, 1'b1);

    report();
  end

endmodule